// File: doc/BRIEF.md
# Two-Tier Priority Arbiter With Fair Ties

This block picks one of N clients each clock cycle. Every client presents a request bit and has a priority level. The arbiter first finds the highest level held by any active requester. It then shares the grant among the requesters at that level in round-robin order, one cycle each. A client at a strictly higher level wins on the next decision, whatever the rotation state is.

Each client's level comes from one of two sources, fixed when the block is built. In dynamic mode the level is read from an input port on every decision. In static mode it is taken from a parameter vector, and the input port is ignored. The outputs are registered: a one-hot grant vector, the binary index of the granted client and a valid flag. All three reflect the requests and levels sampled at the previous rising clock edge.

Top module: `ttarb_top`

## Requirements
- R1: While rst_n is low, and right after it rises, gnt_o is all zeros, gnt_vld_o is 0 and gnt_idx_o is 0, whatever req_i holds.
- R2: Client i's level is the 4-bit unsigned field prio_i[4*i+3:4*i], and a larger value means higher priority. The grant goes to a requester whose level equals the largest level among all requesters.
- R3: When several requesters share the top level, the grant goes to the first of them found by searching upward from the index after the last granted client, wrapping from N-1 to 0. After reset the search starts at client 0.
- R4: Clients whose req_i bit is 0 are skipped by the search. A lone requester at the top level is granted on every cycle it requests.
- R5: A cycle with req_i all zero produces gnt_o = 0 and gnt_vld_o = 0. It leaves gnt_idx_o and the round-robin pointer unchanged.
- R6: The outputs are registered. req_i and prio_i sampled at rising edge k decide the outputs seen after edge k. A change on prio_i therefore acts at the very next decision.
- R7: gnt_o has at most one bit set. gnt_vld_o equals the OR of gnt_o. When gnt_vld_o is 1, gnt_idx_o is the position of the set bit.
- R8: There is a single rotation pointer. A grant won at a higher level also moves it, so later ties at any level resume from the client after that winner.
- R9: With DYN_PRIO = 0, client i's level is STATIC_PRIO[4*i+3:4*i] and prio_i has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CLIENTS | Request bit per client |
| prio_i | input | N_CLIENTS*PRIO_W | Packed run-time level per client (client i at bits PRIO_W*i upward) |
| gnt_o | output | N_CLIENTS | One-hot registered grant |
| gnt_idx_o | output | clog2(N_CLIENTS) | Index of the granted client |
| gnt_vld_o | output | 1 | A grant is present this cycle |

## Verification
The bench targets five corner cases:
- Ties are resumed from the client after the last winner, including when that winner came from a higher level. A design that restarts the search at client 0 starves the upper clients. A design that keeps one pointer per level repeats a client.
- Idle cycles are placed between bursts. A pointer that drifts while no request is present shows up as a skipped client.
- The level vector is changed on every cycle. Any extra register stage on the priority path, or a level sampled a cycle late, shows up as a wrong winner.
- Sparse request patterns check that the rotation skips non-requesters instead of stalling on them.
- A static-level instance is driven with misleading run-time levels to show that the port is ignored.

// File: rtl/ttarb_pkg.sv
package ttarb_pkg;

    // Width of a binary index able to address n clients (at least 1 bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ttarb_prio_src.sv
// Selects where each client's level comes from: the run-time port or a
// build-time constant vector.
module ttarb_prio_src #(
    parameter int unsigned N_CLIENTS   = 4,
    parameter int unsigned PRIO_W      = 4,
    parameter bit          DYN_PRIO    = 1'b1,
    parameter logic [N_CLIENTS*PRIO_W-1:0] STATIC_PRIO = '0
) (
    input  logic [N_CLIENTS*PRIO_W-1:0] prio_i,
    output logic [N_CLIENTS*PRIO_W-1:0] prio_eff_o
);

    generate
        if (DYN_PRIO) begin : g_dynamic
            assign prio_eff_o = prio_i;
        end else begin : g_static
            // The run-time port is deliberately left without effect (R9).
            logic unused_prio;
            assign unused_prio = ^prio_i;
            assign prio_eff_o  = STATIC_PRIO;
        end
    endgenerate

endmodule

// File: rtl/ttarb_level.sv
// First tier: find the largest level among requesters and mark every
// requester holding it.
module ttarb_level #(
    parameter int unsigned N_CLIENTS = 4,
    parameter int unsigned PRIO_W    = 4
) (
    input  logic [N_CLIENTS-1:0]        req_i,
    input  logic [N_CLIENTS*PRIO_W-1:0] prio_i,
    output logic [N_CLIENTS-1:0]        top_mask_o
);

    logic [PRIO_W-1:0] top_lvl;

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < int'(N_CLIENTS); i++) begin
            if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > top_lvl)) begin
                top_lvl = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < int'(N_CLIENTS); i++) begin
            top_mask_o[i] = req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] == top_lvl);
        end
    end

endmodule

// File: rtl/ttarb_rr.sv
// Second tier: rotating pick among the marked clients, searching upward
// from the slot after the last winner.
module ttarb_rr #(
    parameter int unsigned N_CLIENTS = 4,
    localparam int unsigned IW = ttarb_pkg::idx_w(N_CLIENTS)
) (
    input  logic [N_CLIENTS-1:0] mask_i,
    input  logic [IW-1:0]        last_i,
    output logic [IW-1:0]        win_o,
    output logic                 found_o
);

    always_comb begin
        win_o   = '0;
        found_o = 1'b0;
        for (int k = 1; k <= int'(N_CLIENTS); k++) begin
            if (!found_o && mask_i[(int'(last_i) + k) % int'(N_CLIENTS)]) begin
                win_o   = IW'((int'(last_i) + k) % int'(N_CLIENTS));
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ttarb_top.sv
module ttarb_top #(
    parameter int unsigned N_CLIENTS   = 4,
    parameter int unsigned PRIO_W      = 4,
    parameter bit          DYN_PRIO    = 1'b1,
    parameter logic [N_CLIENTS*PRIO_W-1:0] STATIC_PRIO = '0,
    localparam int unsigned IW = ttarb_pkg::idx_w(N_CLIENTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CLIENTS-1:0]        req_i,
    input  logic [N_CLIENTS*PRIO_W-1:0] prio_i,
    output logic [N_CLIENTS-1:0]        gnt_o,
    output logic [IW-1:0]               gnt_idx_o,
    output logic                        gnt_vld_o
);

    typedef struct packed {
        logic [N_CLIENTS-1:0] gnt;
        logic [IW-1:0]        idx;
        logic                 vld;
        logic [IW-1:0]        last;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N_CLIENTS*PRIO_W-1:0] prio_eff;
    logic [N_CLIENTS-1:0]        top_mask;
    logic [IW-1:0]               win;
    logic                        found;

    ttarb_prio_src #(
        .N_CLIENTS  (N_CLIENTS),
        .PRIO_W     (PRIO_W),
        .DYN_PRIO   (DYN_PRIO),
        .STATIC_PRIO(STATIC_PRIO)
    ) u_src (
        .prio_i    (prio_i),
        .prio_eff_o(prio_eff)
    );

    ttarb_level #(
        .N_CLIENTS(N_CLIENTS),
        .PRIO_W   (PRIO_W)
    ) u_level (
        .req_i     (req_i),
        .prio_i    (prio_eff),
        .top_mask_o(top_mask)
    );

    ttarb_rr #(
        .N_CLIENTS(N_CLIENTS)
    ) u_rr (
        .mask_i (top_mask),
        .last_i (st_q.last),
        .win_o  (win),
        .found_o(found)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = '0;
        st_d.vld = 1'b0;
        if (found) begin
            st_d.gnt      = '0;
            st_d.gnt[win] = 1'b1;
            st_d.idx      = win;
            st_d.vld      = 1'b1;
            st_d.last     = win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gnt  <= '0;
            st_q.idx  <= '0;
            st_q.vld  <= 1'b0;
            st_q.last <= IW'(N_CLIENTS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o     = st_q.gnt;
    assign gnt_idx_o = st_q.idx;
    assign gnt_vld_o = st_q.vld;

    // R7: grant vector never has more than one bit set
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R7: valid flag agrees with the grant vector and the index
    a_r7_vld_match: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> (gnt_o[gnt_idx_o] && $countones(gnt_o) == 1));

    // R5: an idle cycle yields no grant and keeps the index
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_i) |=> (!gnt_vld_o && $stable(gnt_idx_o)));

    // R4: any request produces a grant at the next edge
    a_r4_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> gnt_vld_o);

    // R2: the granted client was requesting when the decision was taken
    a_r2_was_req: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> |(gnt_o & $past(req_i)));

endmodule

// File: tb/tb_ttarb_top.sv
module tb_ttarb_top;

    localparam int N  = 4;
    localparam int PW = 4;
    localparam int IW = 2;
    localparam logic [N*PW-1:0] SPRIO = 16'h3931; // c0=1 c1=3 c2=9 c3=3

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N*PW-1:0] prio = '0;
    logic [N-1:0]    gnt, sgnt;
    logic [IW-1:0]   gidx, sidx;
    logic            gvld, svld;

    always #10 clk = ~clk; // 50 MHz

    ttarb_top #(.N_CLIENTS(N), .PRIO_W(PW), .DYN_PRIO(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
        .gnt_o(gnt), .gnt_idx_o(gidx), .gnt_vld_o(gvld));

    ttarb_top #(.N_CLIENTS(N), .PRIO_W(PW), .DYN_PRIO(1'b0), .STATIC_PRIO(SPRIO)) dut_stat (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
        .gnt_o(sgnt), .gnt_idx_o(sidx), .gnt_vld_o(svld));

    typedef struct {
        int    due;
        int    exp_d;
        int    exp_s;
        string tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int mptr = N - 1;
    int sptr = N - 1;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference pick from the requirements: top level first, then rotation.
    function automatic int pick(input logic [N-1:0] r, input logic [N*PW-1:0] p, input int last);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && int'(p[i*PW +: PW]) > best) best = int'(p[i*PW +: PW]);
        if (best < 0) return -1;
        for (int k = 1; k <= N; k++) begin
            if (r[(last + k) % N] && int'(p[((last + k) % N)*PW +: PW]) == best)
                return (last + k) % N;
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(input logic [N-1:0] r, input logic [N*PW-1:0] p, input string tag);
        item_t it;
        @(posedge clk);
        #2;
        req  = r;
        prio = p;
        it.due   = cyc + 1;
        it.tag   = tag;
        it.exp_d = pick(r, p, mptr);
        it.exp_s = pick(r, SPRIO, sptr);
        if (it.exp_d >= 0) mptr = it.exp_d;
        if (it.exp_s >= 0) sptr = it.exp_s;
        q.push_back(it);
    endtask

    task automatic cmp_one(input string tag, input int e, input logic [N-1:0] g,
                           input logic [IW-1:0] ix, input logic v);
        if (e < 0) begin
            check(v == 1'b0, tag, "vld(idle)", int'(v), 0);
            check(g == '0, tag, "gnt(idle)", int'(g), 0);
        end else begin
            check(v == 1'b1, tag, "vld", int'(v), 1);
            check(int'(ix) == e, tag, "idx", int'(ix), e);
            check(g == N'(1 << e), "R7", "gnt onehot", int'(g), 1 << e);
        end
    endtask

    // Monitor: pop items whose decision edge has just passed.
    always @(posedge clk) begin
        #5;
        while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            cmp_one(it.tag, it.exp_d, gnt, gidx, gvld);
            cmp_one("R9", it.exp_s, sgnt, sidx, svld);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        // R1: outputs stay cleared while reset is held with requests present
        req = '1;
        repeat (3) @(posedge clk);
        #5;
        check(gnt == '0 && gvld == 1'b0, "R1", "gnt/vld in reset", int'(gnt), 0);
        check(gidx == '0, "R1", "idx in reset", int'(gidx), 0);
        @(negedge clk);
        req = '0;
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check(gvld == 1'b0 && gnt == '0, "R1", "after reset", int'(gvld), 0);

        // R4: lone requester granted every cycle
        repeat (3) step(4'b0100, '0, "R4");
        // R3: equal levels rotate starting after the last winner
        repeat (5) step(4'b1111, '0, "R3");
        // R4: sparse pattern skips non-requesters
        repeat (3) step(4'b1010, '0, "R4");
        // R5: idle cycles keep pointer, then rotation resumes
        repeat (2) step(4'b0000, '0, "R5");
        repeat (3) step(4'b1111, '0, "R5");
        // R2: client 1 at level 7 beats the others at level 2
        repeat (3) step(4'b1111, 16'h2272, "R2");
        // R8: a tie afterwards resumes after the high-level winner
        repeat (3) step(4'b1111, 16'h5555, "R8");
        // R6: level vector changes every cycle and acts at once
        for (int i = 0; i < 8; i++) begin
            logic [N*PW-1:0] p;
            p = 16'h1111;
            p[(i % N)*PW +: PW] = 4'hE;
            step(4'b1111, p, "R6");
        end
        // R2/R3 mixed: pseudo-random requests and levels
        lf = 8'hA5;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[3:0], {lf[7:6], 2'b01, lf[5:4], lf[1:0], 2'b10, lf[7:6], 1'b0, lf[2:0]}, "R3");
        end
        // R9: run-time levels favouring client 0 must not affect the static instance
        repeat (3) step(4'b1111, 16'h000F, "R2");
        repeat (4) step(4'b1011, 16'hF000, "R3");
        step(4'b0000, '0, "R5");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule